// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and date as packed BCD: seconds, minutes, hours (24-hour only), weekday, day of month, month and a two-digit year from 00 to 99, which stands for 2000 to 2099. It advances on a slow tick enable that a 32.768 kHz source supplies. A prescaler turns `TICKS_PER_SEC` slow ticks into one second. Each second carries up through the fields. The day limit follows the month and the leap year.

Software reads the running time from seven read-only count registers. It changes the time through seven separate set registers. To change the time, software raises a hold request, waits for the hold acknowledge, writes the set registers and clears the request. When the acknowledge rises, the set registers take a copy of the frozen count, so fields that software does not rewrite keep their present value. When the request is cleared, all seven set values load into the count, and counting resumes from them. The count registers are read a field at a time, so a read taken while counting runs can straddle a carry. Software reads the seconds a second time and reads again if the value changed.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset the counter is disabled. The count reads 00:00:00 with day 01, month 01, year 00 and weekday 6. The run-control register (address 0x0) reads 0x02, and the hold register (address 0x1) reads 0x00.
- R2: Counting runs only when bit 0 of the run-control register is 1 and no hold is pending or acknowledged. While it runs, seconds advance once every `TICKS_PER_SEC` slow ticks. After a load, the first advance falls on the `TICKS_PER_SEC`-th tick.
- R3: Writing 1 to bit 0 of the hold register (address 0x1) requests a hold. Bit 1 (acknowledge) rises on the second slow tick after the write. From then on, the count stays frozen.
- R4: Writing 0 to the hold bit while acknowledged loads all seven set registers into the count on the second slow tick after the write. The acknowledge falls on that same tick.
- R5: When the acknowledge rises, each set register (addresses 0x2 to 0x8: sec, min, hour, weekday, day, month, year) captures the current count value.
- R6: Seconds and minutes wrap from 59 to 00 with a carry, and hours wrap from 23 to 00 with a carry.
- R7: The day wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February.
- R8: February ends on day 29 when the BCD year is a multiple of four, year 00 included, and on day 28 otherwise.
- R9: The weekday steps 0 to 6 and back to 0 on every day carry.
- R10: Month 12 wraps to 01 and increments the year. Year 99 wraps to 00.
- R11: Writes to the count registers (addresses 0x9 to 0xF) are ignored. Bit 1 of the run-control register always reads 1, because only 24-hour mode exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowTick | input | 1 | One-cycle enable per 32.768 kHz period |
| busAddr | input | 4 | Register address |
| busWe | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for `busAddr`, combinational |

## Verification
Read data is combinational, so any register write shows at the next sample after the edge that takes it. The hold acknowledge is due two slow ticks after the request edge. The load and the fall of the acknowledge are due two ticks after the release edge. The first seconds advance lands `TICKS_PER_SEC` ticks after the load. The bench drives a slow tick on every clock and samples at the falling edge. For these timing checks it samples exactly one cycle before and at the due edge. For rollover vectors it freezes the counter with a hold issued half a second after the expected last advance, so each result is read stable and cannot fall near an edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int FIELDS = 7;
  localparam int ADDR_W = 4;
  localparam int SET_BASE = 2;
  localparam int CNT_BASE = SET_BASE + FIELDS;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] day;
    logic [7:0] month;
    logic [7:0] year;
  } calTime_t;

  typedef struct packed {
    logic              step;
    logic              load;
    logic              capture;
    logic [FIELDS-1:0] setWe;
  } calStrobe_t;

  localparam calTime_t RESET_TIME = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                      wday: 8'h06, day: 8'h01, month: 8'h01,
                                      year: 8'h00};

  function automatic logic [7:0] getField(calTime_t t, int idx);
    case (idx)
      0:       return t.sec;
      1:       return t.min;
      2:       return t.hour;
      3:       return t.wday;
      4:       return t.day;
      5:       return t.month;
      default: return t.year;
    endcase
  endfunction

  function automatic logic [7:0] bcdInc(logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Binary year divisible by 4: even tens with ones 0/4/8, odd tens with ones 2/6.
  function automatic logic isLeap(logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] monthEnd(logic [7:0] m, logic [7:0] y);
    case (m)
      8'h02:                      return isLeap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic calTime_t calNext(calTime_t t);
    calTime_t n;
    n = t;
    if (t.sec != 8'h59) begin
      n.sec = bcdInc(t.sec);
    end else begin
      n.sec = 8'h00;
      if (t.min != 8'h59) begin
        n.min = bcdInc(t.min);
      end else begin
        n.min = 8'h00;
        if (t.hour != 8'h23) begin
          n.hour = bcdInc(t.hour);
        end else begin
          n.hour = 8'h00;
          n.wday = (t.wday >= 8'h06) ? 8'h00 : t.wday + 8'h01;
          if (t.day != monthEnd(t.month, t.year)) begin
            n.day = bcdInc(t.day);
          end else begin
            n.day = 8'h01;
            if (t.month != 8'h12) begin
              n.month = bcdInc(t.month);
            end else begin
              n.month = 8'h01;
              n.year  = (t.year == 8'h99) ? 8'h00 : bcdInc(t.year);
            end
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              wrLsb,
  output calStrobe_t        strb,
  output logic              runEnable,
  output logic              holdReq,
  output logic              holdAck
);

  localparam int PW = $clog2(TICKS_PER_SEC);
  localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_SEC - 1);

  logic          holdSync;
  logic [PW-1:0] preCnt;
  logic          running;
  logic          preWrap;

  assign running = runEnable && !holdSync && !holdAck;
  assign preWrap = (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEnable <= 1'b0;
      holdReq   <= 1'b0;
      holdSync  <= 1'b0;
      holdAck   <= 1'b0;
      preCnt    <= '0;
    end else begin
      if (busWe && busAddr == ADDR_W'(0)) runEnable <= wrLsb;
      if (busWe && busAddr == ADDR_W'(1)) holdReq   <= wrLsb;
      if (slowTick) begin
        holdSync <= holdReq;
        holdAck  <= holdSync;
        if (holdAck && !holdSync) preCnt <= '0;
        else if (running)         preCnt <= preWrap ? '0 : preCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.step    = slowTick && running && preWrap;
    strb.load    = slowTick && holdAck && !holdSync;
    strb.capture = slowTick && holdSync && !holdAck;
    for (int i = 0; i < FIELDS; i++)
      strb.setWe[i] = busWe && (busAddr == ADDR_W'(SET_BASE + i));
  end

  a_r3_ack_follows_sync: assert property (@(posedge clk) disable iff (!rstN)
    (slowTick && holdSync && !holdAck) |=> holdAck);
  a_r3_no_step_held: assert property (@(posedge clk) disable iff (!rstN)
    (holdAck || holdSync) |-> !strb.step);
  a_r4_release_drops_ack: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> !holdAck);
  a_r2_step_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> runEnable);

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  calStrobe_t strb,
  input  logic [7:0] wrData,
  output calTime_t   cnt,
  output logic [7:0] setReg [FIELDS]
);

  calTime_t loadVal;

  always_comb begin
    loadVal.sec   = setReg[0];
    loadVal.min   = setReg[1];
    loadVal.hour  = setReg[2];
    loadVal.wday  = setReg[3];
    loadVal.day   = setReg[4];
    loadVal.month = setReg[5];
    loadVal.year  = setReg[6];
  end

  always_ff @(posedge clk) begin
    if (!rstN)          cnt <= RESET_TIME;
    else if (strb.load) cnt <= loadVal;
    else if (strb.step) cnt <= calNext(cnt);
  end

  for (genvar g = 0; g < FIELDS; g++) begin : gSet
    always_ff @(posedge clk) begin
      if (!rstN)               setReg[g] <= getField(RESET_TIME, g);
      else if (strb.setWe[g])  setReg[g] <= wrData;
      else if (strb.capture)   setReg[g] <= getField(cnt, g);
    end
  end

  a_r2_frozen_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.step && !strb.load) |=> (cnt == $past(cnt)));
  a_r9_wday_moves_on_day_carry: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.load && cnt.sec == 8'h59 && cnt.min == 8'h59 && cnt.hour == 8'h23)
    |=> (cnt.wday != $past(cnt.wday)));
  a_r10_month_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.load && cnt.month != 8'h00) |=> (cnt.month != 8'h00));
  a_r6_sec_moves_on_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.load) |=> (cnt.sec != $past(cnt.sec)));

endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       slowTick,
  input  logic [3:0] busAddr,
  input  logic       busWe,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData
);

  calStrobe_t strb;
  calTime_t   cnt;
  logic [7:0] setReg [FIELDS];
  logic       runEnable;
  logic       holdReq;
  logic       holdAck;

  rtc_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .slowTick  (slowTick),
    .busAddr   (busAddr),
    .busWe     (busWe),
    .wrLsb     (busWrData[0]),
    .strb      (strb),
    .runEnable (runEnable),
    .holdReq   (holdReq),
    .holdAck   (holdAck)
  );

  rtc_datapath uData (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (busWrData),
    .cnt    (cnt),
    .setReg (setReg)
  );

  always_comb begin
    busRdData = 8'h00;
    if (busAddr == 4'd0)           busRdData = {6'b0, 1'b1, runEnable};
    else if (busAddr == 4'd1)      busRdData = {6'b0, holdAck, holdReq};
    else if (int'(busAddr) < CNT_BASE) begin
      for (int i = 0; i < FIELDS; i++)
        if (int'(busAddr) == SET_BASE + i) busRdData = setReg[i];
    end else begin
      for (int i = 0; i < FIELDS; i++)
        if (int'(busAddr) == CNT_BASE + i) busRdData = getField(cnt, i);
    end
  end

endmodule

// File: tb/tb_bcd_calendar_rtc.sv
module tb_bcd_calendar_rtc;

  localparam int TPS = 8;
  localparam int NVEC = 14;

  typedef struct packed {
    logic [15:0] tag;
    logic [55:0] start;
    logic [7:0]  secs;
    logic [55:0] expTime;
  } vec_t;

  // field order in each word: sec min hour wday day month year
  localparam vec_t VECS [NVEC] = '{
    '{"R6",  56'h56_34_12_03_15_06_24, 8'd2,  56'h58_34_12_03_15_06_24},
    '{"R10", 56'h59_59_23_06_31_12_99, 8'd1,  56'h00_00_00_00_01_01_00},
    '{"R7",  56'h58_59_23_02_30_04_21, 8'd2,  56'h00_00_00_03_01_05_21},
    '{"R8",  56'h59_59_23_00_28_02_23, 8'd1,  56'h00_00_00_01_01_03_23},
    '{"R8",  56'h59_59_23_00_28_02_24, 8'd1,  56'h00_00_00_01_29_02_24},
    '{"R8",  56'h59_59_23_01_29_02_00, 8'd1,  56'h00_00_00_02_01_03_00},
    '{"R8",  56'h59_59_23_03_28_02_00, 8'd1,  56'h00_00_00_04_29_02_00},
    '{"R6",  56'h59_59_10_04_31_01_30, 8'd1,  56'h00_00_11_04_31_01_30},
    '{"R7",  56'h59_59_23_05_30_09_45, 8'd1,  56'h00_00_00_06_01_10_45},
    '{"R7",  56'h59_59_23_05_31_07_12, 8'd1,  56'h00_00_00_06_01_08_12},
    '{"R7",  56'h59_59_23_03_30_11_76, 8'd1,  56'h00_00_00_04_01_12_76},
    '{"R10", 56'h59_59_23_02_31_12_09, 8'd1,  56'h00_00_00_03_01_01_10},
    '{"R6",  56'h59_00_00_01_05_03_18, 8'd65, 56'h04_02_00_01_05_03_18},
    '{"R9",  56'h59_59_23_06_28_02_12, 8'd1,  56'h00_00_00_00_29_02_12}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       slowTick = 1'b1;
  logic [3:0] busAddr = 4'd0;
  logic       busWe = 1'b0;
  logic [7:0] busWrData = 8'd0;
  logic [7:0] busRdData;

  int nChecks = 0;
  int nFails = 0;

  always #10 clk = ~clk;

  bcd_calendar_rtc #(.TICKS_PER_SEC(TPS)) dut (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .busAddr(busAddr),
    .busWe(busWe), .busWrData(busWrData), .busRdData(busRdData)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // write takes effect at the rising edge inside the task
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWe = 1'b1;
    @(posedge clk);
    #1 busWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic readBank(input int base, output logic [55:0] t);
    logic [7:0] b;
    for (int i = 0; i < 7; i++) begin
      rd(4'(base + i), b);
      t[55-8*i -: 8] = b;
    end
  endtask

  task automatic waitAck();
    logic [7:0] h;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      rd(4'd1, h);
      if (h[1]) break;
    end
  endtask

  task automatic loadSet(input logic [55:0] t);
    for (int i = 0; i < 7; i++) wr(4'(2 + i), t[55-8*i -: 8]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [55:0] t0, t1;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    rd(4'd0, b); check("R1 ctrl", 64'(b), 64'h02);
    rd(4'd1, b); check("R1 hold", 64'(b), 64'h00);
    readBank(9, t0); check("R1 count", 64'(t0), 64'h00_00_00_06_01_01_00);
    repeat (3 * TPS) @(negedge clk);
    readBank(9, t1); check("R2 disabled stays", 64'(t1), 64'(t0));

    // R11 writes to count register and hour-mode bit ignored
    wr(4'd9, 8'h45);
    @(negedge clk);
    rd(4'd9, b); check("R11 count write", 64'(b), 64'h00);
    wr(4'd0, 8'h01);
    @(negedge clk);
    rd(4'd0, b); check("R11 mode bit", 64'(b), 64'h03);

    // R3 exact acknowledge timing
    wr(4'd1, 8'h01);
    @(negedge clk); rd(4'd1, b); check("R3 ack +0", 64'(b), 64'h01);
    @(negedge clk); rd(4'd1, b); check("R3 ack +1", 64'(b), 64'h01);
    @(negedge clk); rd(4'd1, b); check("R3 ack +2", 64'(b), 64'h03);
    readBank(9, t0);
    readBank(2, t1); check("R5 capture", 64'(t1), 64'(t0));
    repeat (3 * TPS) @(negedge clk);
    readBank(9, t1); check("R3 frozen", 64'(t1), 64'(t0));

    // R4 release timing and R2 first step
    loadSet(56'h30_15_08_02_10_10_10);
    wr(4'd1, 8'h00);
    @(negedge clk); rd(4'd1, b); check("R4 ack held +0", 64'(b), 64'h02);
    @(negedge clk); rd(4'd1, b); check("R4 ack held +1", 64'(b), 64'h02);
    @(negedge clk); rd(4'd1, b); check("R4 ack fall +2", 64'(b), 64'h00);
    readBank(9, t0); check("R4 loaded", 64'(t0), 64'h30_15_08_02_10_10_10);
    repeat (TPS - 1) @(negedge clk);
    rd(4'd9, b); check("R2 before step", 64'(b), 64'h30);
    @(negedge clk);
    rd(4'd9, b); check("R2 at step", 64'(b), 64'h31);

    // rollover vectors
    for (int v = 0; v < NVEC; v++) begin
      wr(4'd1, 8'h01);
      waitAck();
      loadSet(VECS[v].start);
      wr(4'd1, 8'h00);
      repeat (TPS * int'(VECS[v].secs) + TPS / 2) @(posedge clk);
      wr(4'd1, 8'h01);
      waitAck();
      readBank(9, t0);
      check(string'(VECS[v].tag), 64'(t0), 64'(VECS[v].expTime));
    end

    // R2 disable while running
    wr(4'd1, 8'h00);
    wr(4'd0, 8'h00);
    repeat (4) @(negedge clk);
    readBank(9, t0);
    repeat (3 * TPS) @(negedge clk);
    readBank(9, t1); check("R2 enable cleared", 64'(t1), 64'(t0));
    rd(4'd0, b); check("R11 mode reads one", 64'(b), 64'h02);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule